// File: doc/BRIEF.md
# Command Transaction Sequencer

This block runs one complete command exchange with a management microcontroller over a mailbox interface. The mailbox has a status word, a transmit data port and a receive data port. The host places an opcode, up to eight parameter bytes with their count, and the number of reply bytes it expects on the inputs, then pulses `start`. The sequencer clears any stale mailbox flags, sends the opcode and then each parameter byte, reads one acknowledge byte, and then reads the reply bytes. When it finishes it raises `done`. If a wait lasts too long it raises `timeout`.

Every wait for transmit space or receive data is bounded by a poll counter. If the microcontroller goes silent, the sequencer abandons the exchange and returns to idle instead of hanging. The bytes travel in the upper lane (bits 15:8) of the 16-bit mailbox data words. A two-byte reply is also presented as a 16-bit word, with the first byte as the high byte. The host uses this word for status reads such as opcode 0x0C or 0x11, which take no parameters and return two bytes.

Top module: `cmd_seq`

## Requirements
- R1: Bytes are sent in this order: the opcode first, then parameter byte i taken from `par_bytes[8i+7:8i]`, for i = 0 to count-1. Each byte is placed in `mb_wr_data[15:8]`, with `mb_wr_data[7:0]` = 0.
- R2: A data write (`mb_wr_en`) happens only in a cycle where transmit-not-full (`mb_stat[1]`) is 1.
- R3: After the last parameter byte, exactly one acknowledge byte is read before any reply byte. It appears on `ack_byte`.
- R4: A read (`mb_rd_en`) happens only when receive-not-empty (`mb_stat[2]`) is 1. The byte is taken from `mb_rd_data[15:8]` (bits 7:0 are ignored). Reply byte k is stored in `reply_bytes[8k+7:8k]` in arrival order. Lanes that are not written read 0 after a start.
- R5: Every read is accompanied in the same cycle by a status write (`mb_stat_wr`) of value 4'b0100, which clears receive-not-empty.
- R6: In the first busy cycle after an accepted start, the sequencer writes the current `mb_stat` value back to the status register, before any data write.
- R7: `reply_word` equals {reply byte 0, reply byte 1}.
- R8: If POLL_LIMIT consecutive polls all find the awaited status bit low, the exchange stops. `timeout` goes to 1, `done` stays 0, `busy` goes to 0, and no further mailbox transfer takes place.
- R9: After the last reply byte, `done` goes to 1. `done` and `timeout` are never both 1. Both hold their value until the next accepted start, which clears them.
- R10: A parameter count or reply count above 8 is treated as 8.
- R11: `start` is ignored while `busy` is 1. The opcode, parameters and counts are latched only when a start is accepted.
- R12: After reset, `busy`, `done`, `timeout`, `mb_wr_en` and `mb_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange (accepted when idle) |
| opcode | input | 8 | Command opcode |
| n_par | input | 4 | Number of parameter bytes |
| par_bytes | input | 64 | Parameter bytes, byte i in lane i |
| n_rep | input | 4 | Number of reply bytes expected |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Last exchange completed |
| timeout | output | 1 | Last exchange abandoned on the poll limit |
| ack_byte | output | 8 | Acknowledge byte of the last exchange |
| reply_bytes | output | 64 | Reply bytes, byte k in lane k |
| reply_word | output | 16 | First two reply bytes, first byte high |
| mb_stat | input | 4 | Mailbox status: bit1 transmit-not-full, bit2 receive-not-empty |
| mb_stat_wr | output | 1 | Status register write strobe |
| mb_stat_wdata | output | 4 | Status write value (ones clear flags) |
| mb_wr_en | output | 1 | Transmit data write strobe |
| mb_wr_data | output | 16 | Transmit data word |
| mb_rd_en | output | 1 | Receive data read strobe |
| mb_rd_data | input | 16 | Receive data word at the FIFO head |

## Verification
The bench stalls transmit space and receive data at random, to catch a design that writes or reads without its status bit, or that loses count of the acknowledge byte and shifts every reply lane by one. Directed cases cover:
- zero parameters with zero replies, where only the acknowledge byte is read;
- counts above eight, which an unclamped design would overrun;
- a transmit stall just short of the poll limit, which an off-by-one counter would wrongly abandon;
- stalls on both the transmit and the receive side that reach the limit, which a design without a bound would hang on.

A second start pulsed in the middle of an exchange, with different inputs, would corrupt the byte stream of a design that does not ignore it. Junk in the low data lane shows up as wrong reply bytes in a design that reads the wrong lane.

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int MAX_CNT    = 8,
  parameter int POLL_LIMIT = 10000,
  localparam int CW = $clog2(2 * MAX_CNT),
  localparam int PW = $clog2(POLL_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [7:0]           opcode,
  input  logic [CW-1:0]        n_par,
  input  logic [8*MAX_CNT-1:0] par_bytes,
  input  logic [CW-1:0]        n_rep,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout,
  output logic [7:0]           ack_byte,
  output logic [8*MAX_CNT-1:0] reply_bytes,
  output logic [15:0]          reply_word,
  input  logic [3:0]           mb_stat,
  output logic                 mb_stat_wr,
  output logic [3:0]           mb_stat_wdata,
  output logic                 mb_wr_en,
  output logic [15:0]          mb_wr_data,
  output logic                 mb_rd_en,
  input  logic [15:0]          mb_rd_data
);

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_TX, S_RX} state_t;

  state_t               state;
  logic [7:0]           op_q;
  logic [8*MAX_CNT-1:0] par_q;
  logic [CW-1:0]        np_q, nr_q, idx;
  logic [PW-1:0]        poll;
  logic                 done_q, to_q;
  logic [7:0]           ack_q;
  logic [8*MAX_CNT-1:0] rep_q;

  wire           tx_ok     = mb_stat[1];
  wire           rx_ok     = mb_stat[2];
  wire           poll_last = (poll == PW'(POLL_LIMIT - 1));
  wire [CW-1:0]  np_c      = (n_par > CW'(MAX_CNT)) ? CW'(MAX_CNT) : n_par;
  wire [CW-1:0]  nr_c      = (n_rep > CW'(MAX_CNT)) ? CW'(MAX_CNT) : n_rep;
  wire [7:0]     tx_byte   = (idx == '0) ? op_q : par_q[7:0];
  wire [7:0]     rx_byte   = mb_rd_data[15:8];

  assign busy          = (state != S_IDLE);
  assign done          = done_q;
  assign timeout       = to_q;
  assign ack_byte      = ack_q;
  assign reply_bytes   = rep_q;
  assign reply_word    = {rep_q[7:0], rep_q[15:8]};
  assign mb_wr_en      = (state == S_TX) && tx_ok;
  assign mb_wr_data    = {tx_byte, 8'h00};
  assign mb_rd_en      = (state == S_RX) && rx_ok;
  assign mb_stat_wr    = (state == S_CLR) || mb_rd_en;
  assign mb_stat_wdata = (state == S_CLR) ? mb_stat : 4'b0100;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= '0;
      par_q  <= '0;
      np_q   <= '0;
      nr_q   <= '0;
      idx    <= '0;
      poll   <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      ack_q  <= '0;
      rep_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q   <= opcode;
          par_q  <= par_bytes;
          np_q   <= np_c;
          nr_q   <= nr_c;
          ack_q  <= '0;
          rep_q  <= '0;
          done_q <= 1'b0;
          to_q   <= 1'b0;
          state  <= S_CLR;
        end
        S_CLR: begin
          idx   <= '0;
          poll  <= '0;
          state <= S_TX;
        end
        S_TX: begin
          if (tx_ok) begin
            poll <= '0;
            if (idx != '0) par_q <= par_q >> 8;
            if (idx == np_q) begin
              idx   <= '0;
              state <= S_RX;
            end else begin
              idx <= idx + CW'(1);
            end
          end else if (poll_last) begin
            to_q  <= 1'b1;
            state <= S_IDLE;
          end else begin
            poll <= poll + PW'(1);
          end
        end
        S_RX: begin
          if (rx_ok) begin
            poll <= '0;
            if (idx == '0) ack_q <= rx_byte;
            for (int k = 0; k < MAX_CNT; k++)
              if (idx == CW'(k + 1)) rep_q[8*k +: 8] <= rx_byte;
            if (idx == nr_q) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              idx <= idx + CW'(1);
            end
          end else if (poll_last) begin
            to_q  <= 1'b1;
            state <= S_IDLE;
          end else begin
            poll <= poll + PW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic [3:0] mb_stat,
  input logic       mb_stat_wr,
  input logic [3:0] mb_stat_wdata,
  input logic       mb_wr_en,
  input logic       mb_rd_en
);

  a_r2_write_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr_en |-> mb_stat[1]);

  a_r4_read_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd_en |-> mb_stat[2]);

  a_r5_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd_en |-> (mb_stat_wr && mb_stat_wdata == 4'b0100));

  a_r6_start_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mb_stat_wr && mb_stat_wdata == mb_stat && !mb_wr_en));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mb_wr_en && !mb_rd_en));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  a_r9_timeout_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(start));

endmodule

bind cmd_seq cmd_seq_chk u_chk (.*);

// File: tb/test_cmd_seq.sv
module test_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [3:0]  n_par = '0, n_rep = '0;
  logic [63:0] par_bytes = '0;
  logic        busy, done, timeout;
  logic [7:0]  ack_byte;
  logic [63:0] reply_bytes;
  logic [15:0] reply_word;
  logic [3:0]  mb_stat = '0;
  logic        mb_stat_wr, mb_wr_en, mb_rd_en;
  logic [3:0]  mb_stat_wdata;
  logic [15:0] mb_wr_data;
  logic [15:0] mb_rd_data = '0;

  always #4 clk = ~clk;

  cmd_seq i_cmd_seq (.*);

  int errors = 0, checks = 0;
  logic [7:0] rq [0:15];
  int rq_head = 0, rq_cnt = 0;
  bit pend_pop = 0, tx_hold = 0, rx_hold = 0;
  logic [7:0] txlog [0:31];
  int tx_n = 0, sw_n = 0;
  bit clr_ok = 0, low_bad = 0;

  always @(negedge clk) begin
    if (pend_pop) begin rq_head++; rq_cnt--; pend_pop = 0; end
    mb_stat[0] = 1'($urandom);
    mb_stat[1] = !tx_hold && ($urandom % 4 != 0);
    mb_stat[2] = !rx_hold && rq_cnt > 0 && ($urandom % 4 != 0);
    mb_stat[3] = 1'($urandom);
    mb_rd_data = {(rq_cnt > 0) ? rq[rq_head] : 8'h00, 8'($urandom)};
    #1;
    if (mb_wr_en) begin
      if (tx_n < 32) txlog[tx_n] = mb_wr_data[15:8];
      if (mb_wr_data[7:0] != 8'h00) low_bad = 1;
      tx_n++;
    end
    if (mb_rd_en) pend_pop = 1;
    if (mb_stat_wr) begin
      if (sw_n == 0) clr_ok = (mb_stat_wdata == mb_stat) && (tx_n == 0);
      sw_n++;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampc(int n);
    return (n > 8) ? 8 : n;
  endfunction

  task automatic run(input logic [7:0] op, input int np, input logic [63:0] pb,
                     input int nr, input logic [7:0] ackv, input logic [63:0] rb,
                     input int nsup, input int txhold, input bit poke, input bit exp_to,
                     input int exp_tx);
    int npc = clampc(np), nrc = clampc(nr);
    int cyc;
    @(posedge clk); #2;
    rq[0] = ackv;
    for (int i = 0; i < 8; i++) rq[i+1] = rb[8*i +: 8];
    rq_head = 0; rq_cnt = nsup;
    tx_n = 0; sw_n = 0; clr_ok = 0; low_bad = 0;
    tx_hold = (txhold != 0); rx_hold = poke;
    opcode = op; n_par = 4'(np); n_rep = 4'(nr); par_bytes = pb;
    start = 1;
    cyc = 0;
    do begin
      @(posedge clk); #2;
      start = 0;
      cyc++;
      if (poke && cyc == 5) begin
        opcode = ~op; n_par = 0; n_rep = 0; par_bytes = ~pb; start = 1;
      end
      if (poke && cyc == 20) rx_hold = 0;
      if (txhold > 0 && cyc == txhold) tx_hold = 0;
    end while (!(done || timeout) && cyc < 30000);
    tx_hold = 0; rx_hold = 0; start = 0;
    chk(timeout == exp_to && done == !exp_to, "R8/R9 outcome", {done, timeout}, {!exp_to, exp_to});
    chk(!busy, "R8/R9 idle after end", busy, 0);
    chk(tx_n == exp_tx, "R1 byte count (R10 clamp)", tx_n, exp_tx);
    chk(!low_bad, "R1 low lane zero", low_bad, 0);
    for (int i = 0; i < exp_tx && i < 9; i++)
      chk(txlog[i] == ((i == 0) ? op : pb[8*(i-1) +: 8]), "R1 byte order (R11)",
          txlog[i], (i == 0) ? op : pb[8*(i-1) +: 8]);
    chk(clr_ok, "R6 start writeback", clr_ok, 1);
    if (!exp_to) begin
      chk(ack_byte == ackv, "R3 ack byte", ack_byte, ackv);
      for (int k = 0; k < 8; k++)
        chk(reply_bytes[8*k +: 8] == ((k < nrc) ? rb[8*k +: 8] : 8'h00), "R4 reply lane",
            reply_bytes[8*k +: 8], (k < nrc) ? rb[8*k +: 8] : 8'h00);
      chk(sw_n == nrc + 2, "R5 clear per read", sw_n, nrc + 2);
      if (nrc >= 2)
        chk(reply_word == {rb[7:0], rb[15:8]}, "R7 reply word", reply_word, {rb[7:0], rb[15:8]});
    end
    repeat (2) @(posedge clk);
    #2;
    chk(done == !exp_to && timeout == exp_to, "R9 flags held", {done, timeout}, {!exp_to, exp_to});
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !done && !timeout && !mb_wr_en && !mb_rd_en, "R12 reset state",
        {busy, done, timeout, mb_wr_en, mb_rd_en}, 0);
    rst_n = 1;
    // R7 status reads, MSB first
    run(8'h0C, 0, 64'h0, 2, 8'hA5, 64'h34_12, 3, 0, 0, 0, 1);
    run(8'h11, 0, 64'h0, 2, 8'h5A, 64'h01_C3, 3, 0, 0, 0, 1);
    // only the ack byte (R3)
    run(8'h30, 0, 64'h0, 0, 8'h77, 64'h0, 1, 0, 0, 0, 1);
    // R10 clamp
    run(8'h42, 12, 64'h8877665544332211, 15, 8'h01, 64'hF8F7F6F5F4F3F2F1, 9, 0, 0, 0, 9);
    // R11 start while busy
    run(8'h21, 2, 64'hBEEF, 1, 8'h02, 64'h9C, 2, 0, 1, 0, 3);
    // R8 stall just under the limit
    run(8'h24, 1, 64'h44, 1, 8'h03, 64'h66, 2, 9990, 0, 0, 2);
    // R8 receive timeout after the ack
    run(8'h0C, 1, 64'h10, 2, 8'h04, 64'h0, 1, 0, 0, 1, 2);
    chk(ack_byte == 8'h04, "R3 ack kept on timeout", ack_byte, 8'h04);
    // R8 transmit timeout
    run(8'h29, 3, 64'h332211, 1, 8'h05, 64'h0, 2, -1, 0, 1, 0);
    chk(sw_n == 1, "R8 no transfer after timeout", sw_n, 1);
    for (int t = 0; t < 25; t++) begin
      int np = $urandom % 9, nr = $urandom % 9;
      logic [63:0] pb = {$urandom, $urandom}, rb = {$urandom, $urandom};
      run(8'($urandom), np, pb, nr, 8'($urandom), rb, nr + 1, 0, 0, 0, np + 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule